// File: doc/BRIEF.md
# Long Multiply-Accumulate Unit

This block multiplies two 32-bit operands into a 64-bit result. It returns the result as a low word and a high word. A 2-bit opcode selects one of four operations: unsigned multiply, unsigned multiply-accumulate, signed multiply and signed multiply-accumulate. The accumulate forms add the product to a 64-bit accumulator, which arrives as separate high and low words. The addition wraps modulo 2^64.

The caller pulses `start` for one cycle with the operands, opcode, accumulator, incoming flags and a flag-update request. The unit works on the multiplier a few bits per cycle, with a shift-and-add datapath of fixed latency. It then raises `done` for exactly one cycle, and in that cycle the result words and flags are valid. When the caller asks for a flag update, the negative and zero flags come from the full 64-bit result, and carry and overflow pass through from the input. Without that request, all four flags leave the unit exactly as they came in. While the unit is busy it ignores `start`. Its outputs keep their values until the next `done`.

Top module: `lmac_unit`

## Requirements
- R1: `op` selects the operation. Bit 1 chooses signed operands and bit 0 chooses accumulate: 00 is unsigned multiply, 01 is unsigned multiply-accumulate, 10 is signed multiply and 11 is signed multiply-accumulate.
- R2: With `op[1]`=0, both operands are unsigned and the 64-bit result is their full unsigned product; for example 0xFFFFFFFF × 0xFFFFFFFF gives 0xFFFFFFFE00000001.
- R3: With `op[1]`=1, both operands are two's complement and the result is their two's complement 64-bit product; for example 0xFFFFFFFF × 0xFFFFFFFF gives 1, and 0x80000000 × 0x80000000 gives 0x4000000000000000.
- R4: `res_lo` carries result bits 31:0 and `res_hi` carries result bits 63:32.
- R5: With `op[0]`=1, the product is added to {`acc_hi`,`acc_lo`} modulo 2^64. No overflow indication is produced.
- R6: The flag vector is ordered [3]=negative, [2]=zero, [1]=carry, [0]=overflow. With `set_flags`=1, the negative flag equals result bit 63, the zero flag is 1 only when all 64 result bits are 0, and bits 1:0 equal `flags_in[1:0]` as captured at start.
- R7: With `set_flags`=0, `flags_out` equals `flags_in` as captured at start.
- R8: `done` is high for exactly one cycle, on the 6th rising edge counted from the edge that accepts `start`, which is edge 1 (STEPS+1 edges later, with STEPS = 32/DIGIT_W = 4 by default). `busy` is high from the accepting edge until `done` rises.
- R9: A `start` raised while `busy` is high is ignored. Its operands do not reach the result, and it produces no extra `done`.
- R10: `res_lo`, `res_hi` and `flags_out` change only in the cycle in which `done` is high, and they hold between pulses.
- R11: After a synchronous reset, `res_lo`, `res_hi`, `flags_out`, `done` and `busy` are all 0.
- R12: A `start` presented in the same cycle as `done` is accepted, and it starts a new operation with the R8 latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request pulse |
| op | input | 2 | Operation select (R1 encoding) |
| set_flags | input | 1 | Request flag update from the result |
| opa | input | 32 | Multiplicand |
| opb | input | 32 | Multiplier |
| acc_lo | input | 32 | Accumulator bits 31:0 |
| acc_hi | input | 32 | Accumulator bits 63:32 |
| flags_in | input | 4 | Incoming flags {N,Z,C,V} |
| res_lo | output | 32 | Result bits 31:0 |
| res_hi | output | 32 | Result bits 63:32 |
| flags_out | output | 4 | Outgoing flags {N,Z,C,V} |
| done | output | 1 | Result-valid pulse |
| busy | output | 1 | Operation in progress |

## Verification
Two things can coincide. In one cycle the unit can present a finished result with `done` and also accept the `start` of the next operation. The bench provokes this on every operation of its sweep by issuing each new request in the same cycle as the previous `done`. It judges the overlap in two ways: the result seen in that cycle must belong to the earlier request, and the new request must reach its own `done` after exactly the R8 latency. A separate sequence raises `start` while the unit is busy, and it checks that neither the result nor the `done` count shows any trace of that request.

// File: rtl/lmac_pkg.sv
package lmac_pkg;

    // Operand width of the unit; the product is twice as wide.
    localparam int unsigned LMAC_W = 32;

    typedef enum logic [1:0] {
        OP_UMUL = 2'b00,
        OP_UMAC = 2'b01,
        OP_SMUL = 2'b10,
        OP_SMAC = 2'b11
    } lmac_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } lmac_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } lmac_flags_t;

    typedef struct packed {
        lmac_op_e              op;
        logic                  upd;
        logic [LMAC_W-1:0]     a;
        logic [LMAC_W-1:0]     b;
        logic [2*LMAC_W-1:0]   acc;
        lmac_flags_t           flg;
    } lmac_req_t;

    function automatic logic op_signed(input lmac_op_e o);
        return o[1];
    endfunction

    function automatic logic op_accum(input lmac_op_e o);
        return o[0];
    endfunction

    // New N and Z from a full-width result; C and V carried from the old set.
    function automatic lmac_flags_t derive_flags(input logic [2*LMAC_W-1:0] r,
                                                 input lmac_flags_t old);
        lmac_flags_t f;
        f.n = r[2*LMAC_W-1];
        f.z = (r == '0);
        f.c = old.c;
        f.v = old.v;
        return f;
    endfunction

endpackage

// File: rtl/lmac_seq.sv
module lmac_seq
    import lmac_pkg::*;
#(
    parameter int unsigned STEPS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic accept,
    output logic step,
    output logic commit,
    output logic busy
);
    localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    lmac_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (start) state_q <= ST_RUN;
                end
                ST_RUN: begin
                    if (cnt_q == LAST) state_q <= ST_FIN;
                    else               cnt_q   <= cnt_q + 1'b1;
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign accept = (state_q == ST_IDLE) && start;
    assign step   = (state_q == ST_RUN);
    assign commit = (state_q == ST_FIN);
    assign busy   = (state_q != ST_IDLE);

endmodule

// File: rtl/lmac_shiftadd.sv
module lmac_shiftadd #(
    parameter int unsigned W       = 32,
    parameter int unsigned DIGIT_W = 8   // must divide W and be smaller than W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] prod
);
    localparam int unsigned PP_W = W + DIGIT_W;

    logic [W-1:0]   mcand_q;
    logic [2*W-1:0] prod_q;
    logic [PP_W-1:0] row [DIGIT_W];
    logic [PP_W-1:0] pp;
    logic [PP_W-1:0] sum;

    // One gated, shifted copy of the multiplicand per multiplier bit of the digit.
    for (genvar i = 0; i < DIGIT_W; i++) begin : g_row
        assign row[i] = prod_q[i] ? ({{DIGIT_W{1'b0}}, mcand_q} << i) : '0;
    end

    always_comb begin
        pp = '0;
        for (int i = 0; i < DIGIT_W; i++) pp = pp + row[i];
    end

    assign sum = {{DIGIT_W{1'b0}}, prod_q[2*W-1:W]} + pp;

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (load) begin
            mcand_q <= mcand_in;
            prod_q  <= {{W{1'b0}}, mplier_in};
        end else if (step) begin
            prod_q  <= {sum, prod_q[W-1:DIGIT_W]};
        end
    end

    assign prod = prod_q;

endmodule

// File: rtl/lmac_finish.sv
module lmac_finish
    import lmac_pkg::*;
(
    input  lmac_req_t             req,
    input  logic [2*LMAC_W-1:0]   uprod,
    output logic [2*LMAC_W-1:0]   result,
    output lmac_flags_t           flags
);
    localparam int unsigned W = LMAC_W;

    logic [2*W-1:0] corr;
    logic [2*W-1:0] addend;

    // Signed product = unsigned product minus 2^W times each operand whose partner is negative.
    always_comb begin
        corr = '0;
        if (op_signed(req.op)) begin
            if (req.a[W-1]) corr = corr + {req.b, {W{1'b0}}};
            if (req.b[W-1]) corr = corr + {req.a, {W{1'b0}}};
        end
    end

    assign addend = op_accum(req.op) ? req.acc : '0;
    assign result = uprod - corr + addend;
    assign flags  = req.upd ? derive_flags(result, req.flg) : req.flg;

endmodule

// File: rtl/lmac_unit.sv
module lmac_unit
    import lmac_pkg::*;
#(
    parameter int unsigned DIGIT_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [1:0]  op,
    input  logic        set_flags,
    input  logic [31:0] opa,
    input  logic [31:0] opb,
    input  logic [31:0] acc_lo,
    input  logic [31:0] acc_hi,
    input  logic [3:0]  flags_in,
    output logic [31:0] res_lo,
    output logic [31:0] res_hi,
    output logic [3:0]  flags_out,
    output logic        done,
    output logic        busy
);
    localparam int unsigned W     = LMAC_W;
    localparam int unsigned STEPS = W / DIGIT_W;

    logic           accept, step, commit;
    lmac_req_t      req_d, req_q;
    logic [2*W-1:0] uprod, result;
    lmac_flags_t    fin_flags, flags_q;
    logic [2*W-1:0] res_q;
    logic           done_q;

    lmac_seq #(.STEPS(STEPS)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .accept (accept),
        .step   (step),
        .commit (commit),
        .busy   (busy)
    );

    always_comb begin
        req_d.op  = lmac_op_e'(op);
        req_d.upd = set_flags;
        req_d.a   = opa;
        req_d.b   = opb;
        req_d.acc = {acc_hi, acc_lo};
        req_d.flg = lmac_flags_t'(flags_in);
    end

    always_ff @(posedge clk) begin
        if (rst)         req_q <= '0;
        else if (accept) req_q <= req_d;
    end

    lmac_shiftadd #(.W(W), .DIGIT_W(DIGIT_W)) u_mul (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .step      (step),
        .mcand_in  (opa),
        .mplier_in (opb),
        .prod      (uprod)
    );

    lmac_finish u_fin (
        .req    (req_q),
        .uprod  (uprod),
        .result (result),
        .flags  (fin_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            flags_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= commit;
            if (commit) begin
                res_q   <= result;
                flags_q <= fin_flags;
            end
        end
    end

    assign res_lo    = res_q[W-1:0];
    assign res_hi    = res_q[2*W-1:W];
    assign flags_out = flags_q;
    assign done      = done_q;

endmodule

// File: rtl/lmac_unit_chk.sv
module lmac_unit_chk #(
    parameter int unsigned LAT = 5
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [31:0] res_lo,
    input logic [31:0] res_hi,
    input logic [3:0]  flags_out,
    input logic        upd,
    input logic [3:0]  flg_cap
);
    localparam int unsigned CW = $clog2(LAT + 1) + 1;

    logic [CW-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (rst)       bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1'b1;
        else           bcnt <= '0;
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (bcnt == CW'(LAT)));

    // R9
    busy_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6
    flag_update_chk: assert property (@(posedge clk) disable iff (rst)
        (done && upd) |-> (flags_out[3] == res_hi[31]) &&
                          (flags_out[2] == ({res_hi, res_lo} == '0)) &&
                          (flags_out[1:0] == flg_cap[1:0]));

    // R7
    flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !upd) |-> (flags_out == flg_cap));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(res_lo) && $stable(res_hi) && $stable(flags_out)));

endmodule

bind lmac_unit lmac_unit_chk #(.LAT(STEPS + 1)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .res_lo    (res_lo),
    .res_hi    (res_hi),
    .flags_out (flags_out),
    .upd       (req_q.upd),
    .flg_cap   (req_q.flg)
);

// File: tb/tb_lmac_unit.sv
`timescale 1ns/1ps
module tb_lmac_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic        set_flags = 1'b0;
    logic [31:0] opa = '0, opb = '0, acc_lo = '0, acc_hi = '0;
    logic [3:0]  flags_in = '0;
    logic [31:0] res_lo, res_hi;
    logic [3:0]  flags_out;
    logic        done, busy;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    lmac_unit dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .set_flags(set_flags),
        .opa(opa), .opb(opb), .acc_lo(acc_lo), .acc_hi(acc_hi),
        .flags_in(flags_in), .res_lo(res_lo), .res_hi(res_hi),
        .flags_out(flags_out), .done(done), .busy(busy)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] val(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            5: return 32'h1234_5678;
            6: return 32'hDEAD_BEEF;
            default: return 32'h0001_0000;
        endcase
    endfunction

    function automatic logic [63:0] model(input logic [1:0] o, input logic [31:0] a,
                                          input logic [31:0] b, input logic [63:0] acc);
        logic [63:0] p;
        if (o[1]) p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
        else      p = {32'b0, a} * {32'b0, b};
        if (o[0]) p = p + acc;
        return p;
    endfunction

    // Called at a falling edge; returns at the falling edge where done is seen.
    task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                          input logic [63:0] acc, input logic u, input logic [3:0] fi,
                          input logic [63:0] exp, input string tag);
        logic [3:0] ef;
        int k;
        ef = u ? {exp[63], (exp == 64'd0), fi[1:0]} : fi;
        op = o; opa = a; opb = b; acc_hi = acc[63:32]; acc_lo = acc[31:0];
        set_flags = u; flags_in = fi; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (!done && k < 40) begin
            @(negedge clk);
            k++;
        end
        check(k == 6, {tag, " R8 latency"}, 64'(k), 64'd6);
        check(res_lo == exp[31:0], {tag, " R4 low word"}, {32'b0, res_lo}, {32'b0, exp[31:0]});
        check(res_hi == exp[63:32], {tag, " R4 high word"}, {32'b0, res_hi}, {32'b0, exp[63:32]});
        check(flags_out == ef, u ? {tag, " R6 flags"} : {tag, " R7 flags"},
              {60'b0, flags_out}, {60'b0, ef});
    endtask

    task automatic finish_up;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check({res_hi, res_lo} == 64'd0, "R11 result", {res_hi, res_lo}, 64'd0);
        check({flags_out, done, busy} == 6'd0, "R11 flags/done/busy",
              {58'b0, flags_out, done, busy}, 64'd0);

        // Corner cases, expected values written out (R2, R3, R5)
        run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 64'd0, 1'b1, 4'h0,
               64'h4000_0000_0000_0000, "R2 umul 8000_0000^2");
        run_op(2'b10, 32'h8000_0000, 32'h8000_0000, 64'd0, 1'b1, 4'h0,
               64'h4000_0000_0000_0000, "R3 smul 8000_0000^2");
        run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 1'b1, 4'h3,
               64'hFFFF_FFFE_0000_0001, "R2 umul FFFF_FFFF^2");
        run_op(2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 1'b1, 4'h0,
               64'h0000_0000_0000_0001, "R3 smul FFFF_FFFF^2");
        run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 4'h2,
               64'hFFFF_FFFE_0000_0000, "R5 umac wrap");
        run_op(2'b01, 32'h0000_0001, 32'h0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 4'h1,
               64'd0, "R5 umac wrap to zero R6");
        run_op(2'b11, 32'h0000_0001, 32'hFFFF_FFFF, 64'd1, 1'b1, 4'hC,
               64'd0, "R5 smac cancel R6");
        run_op(2'b11, 32'h8000_0000, 32'h0000_0001, 64'd0, 1'b0, 4'h5,
               64'hFFFF_FFFF_8000_0000, "R3 smac negative R7");

        // Sweep over all opcodes and operand pairs, each start issued in the done cycle (R1, R12)
        for (int o = 0; o < 4; o++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [63:0] acc;
                    acc = {val((i + 3) % 8), val((j + 5) % 8)};
                    run_op(2'(o), val(i), val(j), acc, 1'((i + j) % 2), 4'(i * 3 + j),
                           model(2'(o), val(i), val(j), acc), "R1 R12 sweep");
                end
            end
        end

        // R9: start while busy is ignored
        begin
            int k;
            int extra;
            op = 2'b10; opa = 32'h8000_0000; opb = 32'h8000_0000;
            acc_hi = '0; acc_lo = '0; set_flags = 1'b0; flags_in = 4'hA; start = 1'b1;
            @(negedge clk);
            op = 2'b01; opa = 32'h1111_1111; opb = 32'h2222_2222;
            acc_hi = 32'h5555_5555; flags_in = 4'h3;
            @(negedge clk);
            @(negedge clk);
            start = 1'b0;
            k = 3;
            while (!done && k < 40) begin
                @(negedge clk);
                k++;
            end
            check(k == 6, "R9 latency unchanged", 64'(k), 64'd6);
            check({res_hi, res_lo} == 64'h4000_0000_0000_0000, "R9 result of first request",
                  {res_hi, res_lo}, 64'h4000_0000_0000_0000);
            check(flags_out == 4'hA, "R9 flags of first request", {60'b0, flags_out}, 64'hA);
            extra = 0;
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (done) extra++;
            end
            check(extra == 0, "R9 no extra done", 64'(extra), 64'd0);
        end

        // R10: outputs hold with inputs moving and no start
        begin
            logic [63:0] held;
            logic [3:0]  hflg;
            int seen;
            held = {res_hi, res_lo};
            hflg = flags_out;
            seen = 0;
            for (int c = 0; c < 12; c++) begin
                opa = 32'(c * 7919); opb = ~32'(c); op = 2'(c); set_flags = 1'(c);
                flags_in = 4'(c);
                @(negedge clk);
                if (done || busy) seen++;
            end
            check({res_hi, res_lo} == held, "R10 result held", {res_hi, res_lo}, held);
            check(flags_out == hflg, "R10 flags held", {60'b0, flags_out}, {60'b0, hflg});
            check(seen == 0, "R10 no activity", 64'(seen), 64'd0);
        end

        finish_up();
    end

endmodule